// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This peripheral holds a set of independent 16-bit compare-match channels. Each channel has a control/status register, an up-counter and a compare register. A single start/stop register holds one run bit per channel.

Every channel advances its counter on a count tick taken from a shared prescaler. The tick rate is the input clock divided by 8, 32, 128 or 512, chosen per channel. When the counter equals the compare value on a tick, the counter returns to zero and the channel raises its match flag. A channel whose interrupt enable is set then drives the shared interrupt line until software clears the flag.

All registers are reached through a plain single-cycle register bus. A write is taken on the clock edge where enable and write are both high. Read data is a combinational function of the address. The bus carries no stream data, so it has no valid/ready handshake and never applies back-pressure.

Top module: `cmt_top`

## Requirements
- R1: After reset, the start/stop register, every control/status register and every counter read 0, every compare register reads 0xFFFF, and `irq` is low.
- R2: Byte offset 0 is the start/stop register. The block for channel n starts at 2+6n and holds control/status at +0, counter at +2 and compare at +4. Compare and counter read back what was written.
- R3: A counter whose run bit (bit n of the start/stop register) is 0 holds its value.
- R4: Control bits 1:0 select the count tick as the input clock divided by 8, 32, 128 or 512 (codes 0 to 3). Match events then repeat every (compare+1) x divisor input clocks.
- R5: On a tick where the counter equals the compare value, the counter becomes 0 and the match flag (control bit 7) is set.
- R6: Writing control bit 7 as 0 clears the match flag, and writing it as 1 leaves the flag unchanged. Bits 6 and 1:0 take the written value. Bits 5:2 and 15:8 read as 0.
- R7: `irq` is high exactly when some channel has both its match flag and its interrupt enable (control bit 6) set.
- R8: Clearing one run bit stops only that channel; the other channels keep counting.
- R9: A bus write to a counter takes priority over counting in the same cycle. A running counter continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the prescaler divides this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: six channels, 16-bit counters and the four prescaler divisors. With these values the last channel block sits at offset 32 and every divisor setting can be exercised. Match periods are measured between consecutive flag rises, so the checks do not depend on the prescaler phase, and periods of a few hundred cycles give exact results for all four divisors. Small compare values keep the runs short, while the 16-bit width covers the reset compare value of 0xFFFF.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int REG_W    = 16;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int SEL_W    = 2;
  localparam int NSEL     = 1 << SEL_W;
  localparam int OFF_CNT  = 2;
  localparam int OFF_CMP  = 4;

  function automatic int chan_base(input int n);
    return 2 + 6 * n;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int NSEL     = 4,
  parameter int LOG_BASE = 3,
  parameter int LOG_STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick_vec
);
  localparam int PRE_W = LOG_BASE + LOG_STEP * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    localparam int TW = LOG_BASE + LOG_STEP * k;
    assign tick_vec[k] = &pre_q[TW-1:0];
    if (k > 0) begin : g_nest
      AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_vec[k] |-> tick_vec[k-1]); // R4
    end
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEL-1:0]  tick_vec,
  input  logic             run,
  input  logic             wr_ctrl,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_req
);
  logic             flag_q, ie_q;
  logic [SEL_W-1:0] cks_q;
  logic             step, hit, match_ev, flag_clr;
  logic             unused_bits;

  assign unused_bits = ^{wdata[REG_W-1:FLAG_BIT+1], wdata[IE_BIT-1:SEL_W]};
  assign step     = run && tick_vec[cks_q];
  assign hit      = step && (cnt_q == cmp_q);
  assign match_ev = hit && !wr_cnt;
  assign flag_clr = wr_ctrl && !wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata[CNT_W-1:0];
    end else if (step) begin
      cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      cks_q  <= '0;
    end else begin
      flag_q <= match_ev | (flag_q & ~flag_clr);
      if (wr_ctrl) begin
        ie_q  <= wdata[IE_BIT];
        cks_q <= wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[FLAG_BIT] = flag_q;
    ctrl_rd[IE_BIT]   = ie_q;
    ctrl_rd[SEL_W-1:0] = cks_q;
  end

  assign irq_req = flag_q & ie_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_vec[cks_q] && cnt_q == cmp_q && !wr_cnt) |=> (cnt_q == '0 && flag_q)); // R5
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(run && tick_vec[cks_q] && cnt_q == cmp_q)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && !wdata[FLAG_BIT])) |=> flag_q); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata[CNT_W-1:0])); // R9
endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(2 + 6 * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [NCH-1:0]   run_q;
  logic [NSEL-1:0]  tick_vec;
  logic             wr, wr_start;
  logic [NCH-1:0]   sel_ctrl, sel_cnt, sel_cmp, irq_vec;
  logic [REG_W-1:0] ctrl_rd [NCH];
  logic [CNT_W-1:0] cnt_rd  [NCH];
  logic [CNT_W-1:0] cmp_rd  [NCH];
  logic             unused_start;

  assign wr       = bus_en && bus_we;
  assign wr_start = wr && (bus_addr == '0);
  assign unused_start = ^bus_wdata[REG_W-1:NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (wr_start) run_q <= bus_wdata[NCH-1:0];
  end

  cmt_prescaler #(.NSEL(NSEL)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign sel_ctrl[n] = bus_addr == ADDR_W'(chan_base(n));
    assign sel_cnt[n]  = bus_addr == ADDR_W'(chan_base(n) + OFF_CNT);
    assign sel_cmp[n]  = bus_addr == ADDR_W'(chan_base(n) + OFF_CMP);

    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec), .run(run_q[n]),
      .wr_ctrl(wr && sel_ctrl[n]), .wr_cnt(wr && sel_cnt[n]),
      .wr_cmp(wr && sel_cmp[n]), .wdata(bus_wdata),
      .ctrl_rd(ctrl_rd[n]), .cnt_q(cnt_rd[n]), .cmp_q(cmp_rd[n]),
      .irq_req(irq_vec[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = REG_W'(run_q);
    for (int n = 0; n < NCH; n++) begin
      if (sel_ctrl[n]) bus_rdata = ctrl_rd[n];
      if (sel_cnt[n])  bus_rdata = REG_W'(cnt_rd[n]);
      if (sel_cmp[n])  bus_rdata = REG_W'(cmp_rd[n]);
    end
  end

  assign irq = |irq_vec;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec == '0) |-> !irq); // R7
  AST_RUN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_start |=> $stable(run_q)); // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ctrl, sel_cnt, sel_cmp})); // R2
endmodule

// File: tb/cmt_top_bench.sv
module cmt_top_bench;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  int    exp_q[$];
  string tag_q[$];
  event  mon_ev;

  always #4 clk = ~clk;

  cmt_top u_cmt_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int cb(input int n); return 2 + 6 * n; endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item and compares against the bus read data.
  initial forever begin
    @(mon_ev);
    check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = ADDR_W'(a);
    #1 d = int'(bus_rdata);
    bus_en = 0;
  endtask

  // Driver: pushes an expected read item, the monitor compares it.
  task automatic expect_rd(input int a, input int e, input string tag);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = ADDR_W'(a);
    #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    -> mon_ev;
    #1 bus_en = 0;
  endtask

  task automatic wait_flag(input int ch, output time t);
    int v;
    t = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(cb(ch), v);
      if (v[7]) begin t = $time; break; end
    end
  endtask

  task automatic period_test(input int ch, input int code, input int cmpv, input int div);
    time t1, t2;
    wr(cb(ch) + 4, cmpv);
    wr(cb(ch), code);
    wr(0, 1 << ch);
    wait_flag(ch, t1);
    wr(cb(ch), code);
    wait_flag(ch, t2);
    check($sformatf("R4 period code %0d", code), int'((t2 - t1) / 8), (cmpv + 1) * div);
    wr(0, 0);
    wr(cb(ch), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, v2;
    time t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_rd(0, 0, "R1 start reg");
    for (int n = 0; n < 6; n++) begin
      expect_rd(cb(n), 0, "R1 ctrl");
      expect_rd(cb(n) + 2, 0, "R1 cnt");
      expect_rd(cb(n) + 4, 16'hFFFF, "R1 cmp");
    end
    check("R1 irq", int'(irq), 0);
    // R2 register map
    wr(cb(5) + 4, 16'hA5C3);
    wr(cb(5) + 2, 16'h0101);
    expect_rd(cb(5) + 4, 16'hA5C3, "R2 cmp ch5");
    expect_rd(cb(5) + 2, 16'h0101, "R2 cnt ch5");
    expect_rd(cb(4) + 4, 16'hFFFF, "R2 cmp ch4 untouched");
    // R3 hold while stopped
    wr(cb(1) + 2, 16'h0042);
    repeat (1200) @(negedge clk);
    expect_rd(cb(1) + 2, 16'h0042, "R3 stopped counter");
    // R4 periods for all divisors
    period_test(2, 0, 3, 8);
    period_test(2, 1, 1, 32);
    period_test(2, 2, 2, 128);
    period_test(2, 3, 0, 512);
    // R5 counter zero right after match
    wr(cb(3) + 2, 0);
    wr(cb(3) + 4, 2);
    wr(cb(3), 3);
    wr(0, 1 << 3);
    wait_flag(3, t);
    expect_rd(cb(3) + 2, 0, "R5 counter after match");
    check("R5 flag seen", int'(t != 0), 1);
    wr(0, 0);
    // R6 flag write semantics (ch3 stopped with flag set)
    wr(cb(3), 16'h00C1);
    expect_rd(cb(3), 16'h00C1, "R6 write one keeps flag");
    wr(cb(3), 16'h003D);
    expect_rd(cb(3), 16'h0001, "R6 write zero clears flag, reserved read 0");
    // R7 irq
    wr(cb(0) + 2, 0);
    wr(cb(0) + 4, 3);
    wr(cb(0), 16'h0040);
    check("R7 irq low without flag", int'(irq), 0);
    wr(0, 1);
    wait_flag(0, t);
    wr(0, 0);
    @(negedge clk);
    check("R7 irq high flag+ie", int'(irq), 1);
    wr(cb(0), 16'h0080);
    @(negedge clk);
    check("R7 irq low when ie cleared", int'(irq), 0);
    wr(cb(0), 16'h0040);
    @(negedge clk);
    check("R7 irq low after flag cleared", int'(irq), 0);
    wr(cb(0), 0);
    // R8 independent stop
    wr(cb(0) + 4, 16'hFFFF);
    wr(cb(1) + 4, 16'hFFFF);
    wr(cb(0) + 2, 0);
    wr(cb(1) + 2, 0);
    wr(0, 3);
    repeat (100) @(negedge clk);
    wr(0, 2);
    rd(cb(0) + 2, v);
    rd(cb(1) + 2, v2);
    repeat (100) @(negedge clk);
    expect_rd(cb(0) + 2, v, "R8 stopped channel holds");
    rd(cb(1) + 2, v);
    check("R8 other channel counts", int'(v > v2), 1);
    // R9 write to a running counter
    wr(cb(1) + 2, 16'h0100);
    rd(cb(1) + 2, v);
    check("R9 running counter loaded", int'(v == 16'h0100 || v == 16'h0101), 1);
    repeat (40) @(negedge clk);
    rd(cb(1) + 2, v);
    check("R9 continues from written value", int'(v >= 16'h0104 && v <= 16'h0106), 1);
    wr(0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule